// File: doc/BRIEF.md
# Parallel Flash Program and Erase Sequencer

This block sits on the host side of a parallel NOR flash bus. It turns high-level requests into the write-cycle sequences the device expects. The requests are: program one word, program a word in the faster bypass mode, leave bypass mode, erase the whole chip, and read the two identification codes. After the last command write of a program or an erase, the block polls the device. It reads the target location in pairs until the toggling status bit stops changing and the ready line is high. It then reports completion. If polling runs longer than a programmable number of clocks, it writes a reset command and reports an error.

Requests use a req/ack handshake. The block accepts one request while idle, acknowledges it in the same cycle and answers it with a one-cycle `done` pulse and an `err` flag. It tracks whether the device is in bypass mode, so that back-to-back bypass programs cost two bus writes each. An input pulse tells the block that the device went through a hardware reset. If this happens during a program, the whole sequence is issued again once the device is ready.

Top module: `flash_seq`

## Requirements
- R1: While and after `rst_n` is low, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are high and `ack`, `done` and `err` are low.
- R2: Op code 0 (single program) issues exactly four writes. The first three carry commands AAh at 555h, 55h at 2AAh and A0h at 555h. The fourth carries the user address and data. A command sits in data bits 7:0 with all upper bits zero, on a zero-extended address.
- R3: During each write, `fl_ce_n` is low and address and data stay unchanged while `fl_we_n` is low. `fl_we_n` is low for exactly WE_CLKS clocks. Between two bus cycles `fl_ce_n` is high for at least REC_CLKS clocks. `fl_we_n` and `fl_oe_n` are never low together, and `fl_we_n` is low only while `fl_ce_n` is low.
- R4: Op code 1 (bypass program) issues AAh@555h, 55h@2AAh, 20h@555h, A0h@000h and then the user address and data when the device is not in bypass mode. It issues only A0h@000h and the user word when it is.
- R5: Op code 2 (bypass exit) writes 90h then 00h, both at address 0, and completes with no polling. The next bypass program issues the full five-write form again.
- R6: After the final write of a program or an erase, the block reads the target address (address 0 for erase) in pairs. It raises `done` with `err` low once bit 6 agrees across a pair while `fl_ready` is high. `done` lasts one cycle.
- R7: Op code 3 (chip erase) writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh and 10h@555h, in that order.
- R8: Op code 4 (identification) writes AAh@555h, 55h@2AAh and 90h@555h. It then reads address 0 into `id_code0` and address 1 into `id_code1`, writes F0h at address 0 and completes.
- R9: No write other than the F0h reset command reaches the bus while `fl_ready` is low.
- R10: When polling has lasted `cfg_timeout` clocks, the block writes F0h at address 0 and raises `done` with `err` high. `err` stays high until the next request is accepted.
- R11: A `fl_rst_evt` pulse during a program or bypass program leads to a reissue. After `fl_ready` is high again, the block restarts the sequence from its first unlock write. Bypass mode counts as lost.
- R12: `ack` is high only in a cycle where `req` is high while the block is idle, and it lasts one cycle. A request made while busy gets no `ack` and does not change the bus traffic. Op codes 5 to 7 are acknowledged and answered with `done` and `err` high and no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request strobe |
| req_op | input | 3 | Operation code (0 program, 1 bypass program, 2 bypass exit, 3 chip erase, 4 identification) |
| req_addr | input | AW | Target word address |
| req_data | input | DW | Word to program |
| cfg_timeout | input | TO_W | Polling limit in clocks |
| ack | output | 1 | Request accepted |
| done | output | 1 | Operation finished, one-cycle pulse |
| err | output | 1 | Last operation timed out or had an unknown op code |
| id_code0 | output | DW | Word read at offset 0 in identification mode |
| id_code1 | output | DW | Word read at offset 1 in identification mode |
| fl_addr | output | AW | Flash address bus |
| fl_dout | output | DW | Flash write data |
| fl_doe | output | 1 | Drive enable for the data bus |
| fl_din | input | DW | Flash read data |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_ready | input | 1 | Device ready (high) or busy (low) |
| fl_rst_evt | input | 1 | Pulse: the device has been hardware reset |

## Verification
The bench builds the block with a 20-bit address, a 32-bit data path and two clocks each for the write pulse, the read strobe and the recovery gap. With these values, pulse widths and gaps can be measured exactly on every cycle. The polling limit is driven to 300 clocks against a modelled device that stays busy for 20 clocks. Normal completion takes several poll pairs, and a device stuck busy reaches the timeout quickly. The device model reacts to the command writes it receives, so bypass entry, bypass loss after a hardware reset and reissued sequences are all seen in the logged writes.

// File: rtl/fseq_pkg.sv
// Shared types for the flash sequencer: operation codes and the
// descriptor of one sequence step. Assumes commands fit in 8 bits and
// command addresses in 12 bits.
package fseq_pkg;

    typedef enum logic [2:0] {
        OP_PROG  = 3'd0,
        OP_BPROG = 3'd1,
        OP_BEXIT = 3'd2,
        OP_ERASE = 3'd3,
        OP_IDENT = 3'd4
    } fseq_op_e;

    typedef struct packed {
        logic        rd;        // step is a read cycle
        logic        last;      // final step of the sequence
        logic        use_user;  // take address/data from the request
        logic [11:0] addr;      // command address
        logic [7:0]  cmd;       // command byte
    } fseq_step_t;

endpackage

// File: rtl/fseq_steps.sv
// Step table: for an operation and a step index, gives the bus cycle to
// issue. Purely combinational. Assumes the caller starts bypass programs
// at index 3 when the device is already in bypass mode.
module fseq_steps
    import fseq_pkg::*;
#(
    parameter logic [11:0] UNLOCK_A = 12'h555,
    parameter logic [11:0] UNLOCK_B = 12'h2AA
) (
    input  fseq_op_e   op,
    input  logic [2:0] idx,
    output fseq_step_t step
);

    // Step decode per operation and index
    always_comb begin
        step = '0;
        if (idx == 3'd0) begin
            step.addr = UNLOCK_A;
            step.cmd  = 8'hAA;
        end else if (idx == 3'd1) begin
            step.addr = UNLOCK_B;
            step.cmd  = 8'h55;
        end
        unique case (op)
            OP_PROG: begin
                if (idx == 3'd2) begin
                    step.addr = UNLOCK_A;
                    step.cmd  = 8'hA0;
                end else if (idx >= 3'd3) begin
                    step.use_user = 1'b1;
                    step.last     = 1'b1;
                end
            end
            OP_BPROG: begin
                if (idx == 3'd2) begin
                    step.addr = UNLOCK_A;
                    step.cmd  = 8'h20;
                end else if (idx == 3'd3) begin
                    step.addr = 12'h000;
                    step.cmd  = 8'hA0;
                end else if (idx >= 3'd4) begin
                    step.use_user = 1'b1;
                    step.last     = 1'b1;
                end
            end
            OP_BEXIT: begin
                step.addr = 12'h000;
                step.cmd  = (idx == 3'd0) ? 8'h90 : 8'h00;
                step.last = (idx != 3'd0);
            end
            OP_ERASE: begin
                if (idx == 3'd2) begin
                    step.addr = UNLOCK_A;
                    step.cmd  = 8'h80;
                end else if (idx == 3'd3) begin
                    step.addr = UNLOCK_A;
                    step.cmd  = 8'hAA;
                end else if (idx == 3'd4) begin
                    step.addr = UNLOCK_B;
                    step.cmd  = 8'h55;
                end else if (idx >= 3'd5) begin
                    step.addr = UNLOCK_A;
                    step.cmd  = 8'h10;
                    step.last = 1'b1;
                end
            end
            OP_IDENT: begin
                if (idx == 3'd2) begin
                    step.addr = UNLOCK_A;
                    step.cmd  = 8'h90;
                end else if (idx == 3'd3 || idx == 3'd4) begin
                    step.rd   = 1'b1;
                    step.addr = (idx == 3'd3) ? 12'h000 : 12'h001;
                    step.cmd  = 8'h00;
                end else if (idx >= 3'd5) begin
                    step.addr = 12'h000;
                    step.cmd  = 8'hF0;
                    step.last = 1'b1;
                end
            end
            default: step = '0;
        endcase
    end

endmodule

// File: rtl/fseq_bus.sv
// Bus cycle engine: runs one read or write cycle on the flash pins.
// A write is one setup clock, WE low for WE_CLKS, one hold clock, then
// REC_CLKS with CE high. A read is the same with OE low for RD_CLKS and
// the data sampled on the last strobe clock. Start is taken only when idle.
module fseq_bus #(
    parameter int AW       = 20,
    parameter int DW       = 32,
    parameter int WE_CLKS  = 2,
    parameter int REC_CLKS = 2,
    parameter int RD_CLKS  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dout,
    output logic          fl_doe,
    input  logic [DW-1:0] fl_din,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);

    localparam int MAXC = (WE_CLKS > RD_CLKS) ?
                          ((WE_CLKS > REC_CLKS) ? WE_CLKS : REC_CLKS) :
                          ((RD_CLKS > REC_CLKS) ? RD_CLKS : REC_CLKS);
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] WE_LEN  = CW'(WE_CLKS - 1);
    localparam logic [CW-1:0] RD_LEN  = CW'(RD_CLKS - 1);
    localparam logic [CW-1:0] REC_LEN = CW'(REC_CLKS - 1);

    typedef enum logic [2:0] {B_IDLE, B_SETUP, B_ACT, B_HOLD, B_REC} bst_e;

    bst_e          st;
    logic [CW-1:0] cnt;
    logic          rd_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    // Cycle phase sequencing and read data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= B_IDLE;
            cnt    <= '0;
            rd_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
            rdata  <= '0;
        end else begin
            unique case (st)
                B_IDLE: if (start) begin
                    rd_q   <= rd;
                    addr_q <= addr;
                    data_q <= wdata;
                    st     <= B_SETUP;
                end
                B_SETUP: begin
                    cnt <= rd_q ? RD_LEN : WE_LEN;
                    st  <= B_ACT;
                end
                B_ACT: begin
                    if (cnt == '0) begin
                        if (rd_q) rdata <= fl_din;
                        st <= B_HOLD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                B_HOLD: begin
                    cnt <= REC_LEN;
                    st  <= B_REC;
                end
                B_REC: begin
                    if (cnt == '0) st <= B_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                default: st <= B_IDLE;
            endcase
        end
    end

    // Pin levels decoded from the phase
    always_comb begin
        fl_addr = addr_q;
        fl_dout = data_q;
        fl_ce_n = !(st == B_SETUP || st == B_ACT || st == B_HOLD);
        fl_we_n = !(st == B_ACT && !rd_q);
        fl_oe_n = !(st == B_ACT && rd_q);
        fl_doe  = !rd_q && !fl_ce_n;
        done    = (st == B_REC) && (cnt == '0);
    end

endmodule

// File: rtl/flash_seq.sv
// Flash program/erase sequencer top. Accepts one request at a time,
// walks the step table through the bus engine, polls completion by
// toggle-bit pairs plus the ready line, handles timeout and device
// hardware-reset reissue, and tracks bypass mode across requests.
// Assumes the user holds req for one cycle per request and keeps
// cfg_timeout stable while an operation runs.
module flash_seq
    import fseq_pkg::*;
#(
    parameter int          AW       = 20,
    parameter int          DW       = 32,
    parameter int          WE_CLKS  = 2,
    parameter int          REC_CLKS = 2,
    parameter int          RD_CLKS  = 2,
    parameter int          TO_W     = 16,
    parameter int          POLL_BIT = 6,
    parameter logic [11:0] UNLOCK_A = 12'h555,
    parameter logic [11:0] UNLOCK_B = 12'h2AA
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [2:0]      req_op,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_data,
    input  logic [TO_W-1:0] cfg_timeout,
    output logic            ack,
    output logic            done,
    output logic            err,
    output logic [DW-1:0]   id_code0,
    output logic [DW-1:0]   id_code1,
    output logic [AW-1:0]   fl_addr,
    output logic [DW-1:0]   fl_dout,
    output logic            fl_doe,
    input  logic [DW-1:0]   fl_din,
    output logic            fl_ce_n,
    output logic            fl_we_n,
    output logic            fl_oe_n,
    input  logic            fl_ready,
    input  logic            fl_rst_evt
);

    typedef enum logic [3:0] {
        S_IDLE, S_ISSUE, S_CYCLE, S_POLL, S_POLLW,
        S_RECOVER, S_ABORT, S_ABORTW, S_DONE
    } st_e;

    st_e             state;
    fseq_op_e        op_q;
    logic [AW-1:0]   addr_q;
    logic [DW-1:0]   data_q;
    logic [2:0]      idx;
    logic            bypass;
    logic            rst_pend;
    logic            second;
    logic            pbit;
    logic            err_q;
    logic [TO_W-1:0] tmo_cnt;
    logic [DW-1:0]   id0, id1;

    fseq_step_t      stp;
    logic            bus_start, bus_rd, bus_done;
    logic [AW-1:0]   bus_addr;
    logic [DW-1:0]   bus_wdata, bus_rdata;
    logic            is_prog, tmo_hit;

    fseq_steps #(.UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)) u_steps (
        .op   (op_q),
        .idx  (idx),
        .step (stp)
    );

    fseq_bus #(
        .AW(AW), .DW(DW), .WE_CLKS(WE_CLKS),
        .REC_CLKS(REC_CLKS), .RD_CLKS(RD_CLKS)
    ) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (bus_start),
        .rd      (bus_rd),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .done    (bus_done),
        .rdata   (bus_rdata),
        .fl_addr (fl_addr),
        .fl_dout (fl_dout),
        .fl_doe  (fl_doe),
        .fl_din  (fl_din),
        .fl_ce_n (fl_ce_n),
        .fl_we_n (fl_we_n),
        .fl_oe_n (fl_oe_n)
    );

    assign is_prog = (op_q == OP_PROG) || (op_q == OP_BPROG);
    assign tmo_hit = (tmo_cnt >= cfg_timeout);

    // Select what the bus engine runs next
    always_comb begin
        bus_start = 1'b0;
        bus_rd    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (state)
            S_ISSUE: begin
                bus_start = 1'b1;
                bus_rd    = stp.rd;
                bus_addr  = stp.use_user ? addr_q : AW'(stp.addr);
                bus_wdata = stp.use_user ? data_q : DW'(stp.cmd);
            end
            S_POLL: begin
                bus_start = !tmo_hit;
                bus_rd    = 1'b1;
                bus_addr  = (op_q == OP_ERASE) ? '0 : addr_q;
            end
            S_ABORT: begin
                bus_start = 1'b1;
                bus_wdata = DW'(8'hF0);
            end
            default: ;
        endcase
    end

    // Request sequencing, polling, timeout and reissue control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            op_q     <= OP_PROG;
            addr_q   <= '0;
            data_q   <= '0;
            idx      <= '0;
            bypass   <= 1'b0;
            rst_pend <= 1'b0;
            second   <= 1'b0;
            pbit     <= 1'b0;
            err_q    <= 1'b0;
            tmo_cnt  <= '0;
            id0      <= '0;
            id1      <= '0;
        end else begin
            if (fl_rst_evt && state != S_IDLE && is_prog) rst_pend <= 1'b1;
            if ((state == S_POLL || state == S_POLLW) && !tmo_hit)
                tmo_cnt <= tmo_cnt + 1'b1;
            unique case (state)
                S_IDLE: if (req) begin
                    err_q    <= 1'b0;
                    rst_pend <= 1'b0;
                    second   <= 1'b0;
                    tmo_cnt  <= '0;
                    addr_q   <= req_addr;
                    data_q   <= req_data;
                    if (req_op > 3'd4) begin
                        err_q <= 1'b1;
                        state <= S_DONE;
                    end else begin
                        op_q  <= fseq_op_e'(req_op);
                        idx   <= (req_op == 3'd1 && bypass) ? 3'd3 : 3'd0;
                        state <= S_ISSUE;
                    end
                end
                S_ISSUE: state <= S_CYCLE;
                S_CYCLE: if (bus_done) begin
                    if (stp.rd) begin
                        if (idx == 3'd3) id0 <= bus_rdata;
                        else             id1 <= bus_rdata;
                    end
                    if (op_q == OP_BPROG && idx == 3'd2) bypass <= 1'b1;
                    if (op_q == OP_BEXIT && stp.last)    bypass <= 1'b0;
                    if (rst_pend)
                        state <= S_RECOVER;
                    else if (stp.last)
                        state <= (is_prog || op_q == OP_ERASE) ? S_POLL : S_DONE;
                    else begin
                        idx   <= idx + 1'b1;
                        state <= S_ISSUE;
                    end
                end
                S_POLL: state <= tmo_hit ? S_ABORT : S_POLLW;
                S_POLLW: if (bus_done) begin
                    if (rst_pend) begin
                        state <= S_RECOVER;
                    end else if (!second) begin
                        pbit   <= bus_rdata[POLL_BIT];
                        second <= 1'b1;
                        state  <= S_POLL;
                    end else begin
                        second <= 1'b0;
                        state  <= (bus_rdata[POLL_BIT] == pbit && fl_ready) ?
                                  S_DONE : S_POLL;
                    end
                end
                S_RECOVER: if (fl_ready && !fl_rst_evt) begin
                    idx      <= '0;
                    rst_pend <= 1'b0;
                    second   <= 1'b0;
                    tmo_cnt  <= '0;
                    state    <= S_ISSUE;
                end
                S_ABORT:  state <= S_ABORTW;
                S_ABORTW: if (bus_done) begin
                    err_q <= 1'b1;
                    state <= S_DONE;
                end
                S_DONE:   state <= S_IDLE;
                default:  state <= S_IDLE;
            endcase
            if (fl_rst_evt) bypass <= 1'b0;
        end
    end

    assign ack      = req && (state == S_IDLE);
    assign done     = (state == S_DONE);
    assign err      = err_q;
    assign id_code0 = id0;
    assign id_code1 = id1;

endmodule

// File: rtl/flash_seq_chk.sv
// Protocol checker for flash_seq, attached by bind. Watches only ports.
module flash_seq_chk #(
    parameter int AW = 20,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req,
    input logic          ack,
    input logic          done,
    input logic          err,
    input logic          fl_ce_n,
    input logic          fl_we_n,
    input logic          fl_oe_n,
    input logic [AW-1:0] fl_addr,
    input logic [DW-1:0] fl_dout
);

    // R3: write strobe only inside chip enable
    a_r3_we_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> !fl_ce_n);

    // R3: never read and write strobes together
    a_r3_no_we_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_oe_n));

    // R3: address and data hold while the write strobe stays low
    a_r3_stable_we: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dout)));

    // R6: completion is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: acceptance is a single-cycle pulse tied to a request
    a_r12_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R10: the error flag only rises together with completion
    a_r10_err_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

endmodule

bind flash_seq flash_seq_chk #(.AW(AW), .DW(DW)) u_flash_seq_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .ack     (ack),
    .done    (done),
    .err     (err),
    .fl_ce_n (fl_ce_n),
    .fl_we_n (fl_we_n),
    .fl_oe_n (fl_oe_n),
    .fl_addr (fl_addr),
    .fl_dout (fl_dout)
);

// File: tb/flash_seq_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural flash device (command decoder, busy timer, toggle
// bit, memory as associative array), write log compared against
// expected queues, per-clock bus protocol checks.
module flash_seq_tb_top;

    localparam int AW = 20, DW = 32, WEC = 2, RECC = 2, RDC = 2;
    localparam int BUSY_CYC = 20;
    localparam logic [31:0] MANUF = 32'h0000_00C2, DEVID = 32'h0000_22BA;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [15:0]   cfg_timeout = 16'd300;
    logic          ack, done, err;
    logic [DW-1:0] id_code0, id_code1;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_dout;
    logic          fl_doe;
    logic [DW-1:0] fl_din = '1;
    logic          fl_ce_n, fl_we_n, fl_oe_n;
    logic          fl_ready;
    logic          fl_rst_evt = 1'b0;

    flash_seq #(.AW(AW), .DW(DW), .WE_CLKS(WEC), .REC_CLKS(RECC),
                .RD_CLKS(RDC), .TO_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .cfg_timeout(cfg_timeout),
        .ack(ack), .done(done), .err(err), .id_code0(id_code0),
        .id_code1(id_code1), .fl_addr(fl_addr), .fl_dout(fl_dout),
        .fl_doe(fl_doe), .fl_din(fl_din), .fl_ce_n(fl_ce_n),
        .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_ready(fl_ready),
        .fl_rst_evt(fl_rst_evt)
    );

    int n_chk = 0, n_fail = 0, cycles = 0;

    function automatic void chk(input bit ok, input string tag,
                                input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endfunction

    // ---------------- device model state ----------------
    typedef enum int {D_RD, D_U1, D_U2, D_PGM, D_BYP, D_BPG, D_BX,
                      D_E1, D_E2, D_E3, D_AUTO} dst_e;
    dst_e          dst = D_RD, ret_st = D_RD;
    int            busy_cnt = 0, rst_cnt = 0;
    bit            hang = 0, hang_next = 0, tog = 0, rst_req = 0, pend_erase = 0;
    logic [31:0]   pend_a, pend_d;
    logic [31:0]   mem [int];
    logic [31:0]   log_a[$], log_d[$], exp_a[$], exp_d[$];
    logic          prev_we = 1'b1, prev_oe = 1'b1, prev_ce = 1'b1;
    int            we_run = 0, ce_high = 100;
    logic [AW-1:0] hold_a;
    logic [DW-1:0] hold_d;
    bit            stable_ok = 1;

    assign fl_ready = (busy_cnt == 0) && !hang && (rst_cnt == 0);

    function automatic void start_busy(input bit erase, input dst_e back);
        pend_erase = erase;
        pend_a = 32'(fl_addr);
        pend_d = fl_dout;
        ret_st = back;
        if (hang_next) begin hang = 1; hang_next = 0; end
        else busy_cnt = BUSY_CYC;
    endfunction

    function automatic void dev_write();
        logic [11:0] a;
        logic [7:0]  c;
        a = fl_addr[11:0];
        c = fl_dout[7:0];
        case (dst)
            D_RD:   dst = (a == 12'h555 && c == 8'hAA) ? D_U1 : D_RD;
            D_U1:   dst = (a == 12'h2AA && c == 8'h55) ? D_U2 : D_RD;
            D_U2:   dst = (c == 8'hA0) ? D_PGM : (c == 8'h20) ? D_BYP :
                          (c == 8'h80) ? D_E1 : (c == 8'h90) ? D_AUTO : D_RD;
            D_PGM:  begin start_busy(0, D_RD); dst = D_RD; end
            D_BYP:  dst = (c == 8'hA0) ? D_BPG : (c == 8'h90) ? D_BX : D_BYP;
            D_BPG:  begin start_busy(0, D_BYP); dst = D_BYP; end
            D_BX:   dst = (c == 8'h00) ? D_RD : D_BYP;
            D_E1:   dst = (c == 8'hAA) ? D_E2 : D_RD;
            D_E2:   dst = (c == 8'h55) ? D_E3 : D_RD;
            D_E3:   if (c == 8'h10) begin start_busy(1, D_RD); dst = D_RD; end
                    else dst = D_RD;
            D_AUTO: dst = (c == 8'hF0) ? D_RD : D_AUTO;
            default: dst = D_RD;
        endcase
    endfunction

    // Device behaviour, protocol checks and watchdog, on the falling edge
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run hung actual=%0d expected<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
        fl_rst_evt = 1'b0;
        if (rst_req) begin
            rst_req = 0;
            fl_rst_evt = 1'b1;
            dst = D_RD;
            busy_cnt = 0;
            rst_cnt = 5;
        end else if (rst_n) begin
            if (rst_cnt > 0) rst_cnt--;
            if (busy_cnt > 0) begin
                busy_cnt--;
                if (busy_cnt == 0) begin
                    if (pend_erase) mem.delete();
                    else mem[int'(pend_a)] = pend_d;
                    dst = ret_st;
                end
            end
            if (!fl_oe_n && prev_oe && (busy_cnt > 0 || hang)) tog = ~tog;
            // R3 per-clock protocol
            if (!fl_we_n) begin
                if (prev_we) begin hold_a = fl_addr; hold_d = fl_dout; stable_ok = 1; end
                else if (fl_addr != hold_a || fl_dout != hold_d) stable_ok = 0;
                if (fl_ce_n || !fl_oe_n) chk(0, "R3 strobe overlap", {fl_ce_n, fl_oe_n}, 2'b01);
                we_run++;
            end
            if (fl_we_n && !prev_we) begin
                chk(we_run == WEC, "R3 WE low width", we_run, WEC);
                chk(stable_ok, "R3 addr/data stable under WE", stable_ok, 1);
                chk(!fl_ce_n, "R3 CE held after WE rise", fl_ce_n, 0);
                chk(fl_ready || fl_dout[7:0] == 8'hF0, "R9 write while busy",
                    fl_dout, 32'hF0);
                log_a.push_back(32'(fl_addr));
                log_d.push_back(fl_dout);
                dev_write();
                we_run = 0;
            end
            if (!fl_ce_n && prev_ce) chk(ce_high >= RECC, "R3 recovery gap", ce_high, RECC);
            ce_high = fl_ce_n ? ce_high + 1 : 0;
        end
        prev_we = fl_we_n;
        prev_oe = fl_oe_n;
        prev_ce = fl_ce_n;
        if (busy_cnt > 0 || hang) fl_din = {25'd0, tog, 6'd0};
        else if (dst == D_AUTO) fl_din = (fl_addr[7:0] == 8'h00) ? MANUF :
                                         (fl_addr[7:0] == 8'h01) ? DEVID : 32'h0;
        else fl_din = mem.exists(int'(fl_addr)) ? mem[int'(fl_addr)] : 32'hFFFF_FFFF;
    end

    // ---------------- bench tasks ----------------
    task automatic ex(input logic [31:0] a, input logic [31:0] d);
        exp_a.push_back(a);
        exp_d.push_back(d);
    endtask

    task automatic ex_unlock();
        ex(32'h555, 32'hAA);
        ex(32'h2AA, 32'h55);
    endtask

    task automatic cmp_log(input string tag);
        chk(log_a.size() == exp_a.size(), {tag, " write count"}, log_a.size(), exp_a.size());
        for (int i = 0; i < exp_a.size() && i < log_a.size(); i++)
            chk(log_a[i] == exp_a[i] && log_d[i] == exp_d[i], {tag, " write"},
                {log_a[i], log_d[i]}, {exp_a[i], exp_d[i]});
        log_a.delete(); log_d.delete(); exp_a.delete(); exp_d.delete();
    endtask

    task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; req_op = op; req_addr = a[AW-1:0]; req_data = d;
        #1;
        chk(ack === 1'b1, "R12 ack when idle", ack, 1);
        @(negedge clk);
        req = 1'b0;
        #1;
        chk(ack === 1'b0, "R12 ack single cycle", ack, 0);
    endtask

    task automatic wait_done(input logic exp_err, input string tag);
        while (done !== 1'b1) @(negedge clk);
        chk(err === exp_err, {tag, " err flag"}, err, exp_err);
        @(negedge clk);
        chk(done === 1'b0, "R6 done one cycle", done, 0);
    endtask

    task automatic run(input logic [2:0] op, input logic [31:0] a, input logic [31:0] d,
                       input logic exp_err, input string tag);
        issue(op, a, d);
        wait_done(exp_err, tag);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(fl_ce_n && fl_we_n && fl_oe_n, "R1 strobes idle in reset",
            {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
        chk(!ack && !done && !err, "R1 handshake idle in reset", {ack, done, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fl_ce_n && fl_we_n && fl_oe_n && !done && !err, "R1 after reset",
            {fl_ce_n, fl_we_n, fl_oe_n, done, err}, 5'b11100);

        // R2 / R6 single program
        ex_unlock(); ex(32'h555, 32'hA0); ex(32'h00123, 32'hDEAD_BEEF);
        run(3'd0, 32'h00123, 32'hDEAD_BEEF, 1'b0, "R6 program");
        cmp_log("R2 program");
        chk(mem.exists(32'h123) && mem[32'h123] == 32'hDEAD_BEEF, "R6 word programmed",
            mem[32'h123], 32'hDEAD_BEEF);

        // R4 bypass programs
        ex_unlock(); ex(32'h555, 32'h20); ex(32'h0, 32'hA0); ex(32'h10, 32'h1111_0001);
        run(3'd1, 32'h10, 32'h1111_0001, 1'b0, "R4 first bypass");
        cmp_log("R4 bypass entry");
        ex(32'h0, 32'hA0); ex(32'h11, 32'h2222_0002);
        run(3'd1, 32'h11, 32'h2222_0002, 1'b0, "R4 second bypass");
        ex(32'h0, 32'hA0); ex(32'h12, 32'h3333_0003);
        run(3'd1, 32'h12, 32'h3333_0003, 1'b0, "R4 third bypass");
        cmp_log("R4 short form");
        chk(mem[32'h11] == 32'h2222_0002 && mem[32'h12] == 32'h3333_0003,
            "R4 bypass words stored", mem[32'h12], 32'h3333_0003);

        // R5 bypass exit then re-entry
        ex(32'h0, 32'h90); ex(32'h0, 32'h00);
        run(3'd2, 32'h0, 32'h0, 1'b0, "R5 exit");
        cmp_log("R5 exit writes");
        ex_unlock(); ex(32'h555, 32'h20); ex(32'h0, 32'hA0); ex(32'h13, 32'h4444_0004);
        run(3'd1, 32'h13, 32'h4444_0004, 1'b0, "R5 re-entry");
        cmp_log("R5 full form after exit");
        ex(32'h0, 32'h90); ex(32'h0, 32'h00);
        run(3'd2, 32'h0, 32'h0, 1'b0, "R5 exit again");
        cmp_log("R5 exit again writes");

        // R11 hardware reset during a single program
        ex_unlock(); ex(32'h555, 32'hA0); ex(32'h200, 32'h5A5A_A5A5);
        ex_unlock(); ex(32'h555, 32'hA0); ex(32'h200, 32'h5A5A_A5A5);
        issue(3'd0, 32'h200, 32'h5A5A_A5A5);
        while (busy_cnt == 0) @(negedge clk);
        repeat (3) @(negedge clk);
        rst_req = 1;
        wait_done(1'b0, "R11 program reissue");
        cmp_log("R11 program reissued");
        chk(mem.exists(32'h200) && mem[32'h200] == 32'h5A5A_A5A5, "R11 word after reissue",
            mem[32'h200], 32'h5A5A_A5A5);

        // R11 hardware reset during a bypass program: bypass counts as lost
        ex_unlock(); ex(32'h555, 32'h20); ex(32'h0, 32'hA0); ex(32'h20, 32'h0000_0020);
        run(3'd1, 32'h20, 32'h20, 1'b0, "R11 bypass setup");
        ex(32'h0, 32'hA0); ex(32'h21, 32'h0000_0021);
        ex_unlock(); ex(32'h555, 32'h20); ex(32'h0, 32'hA0); ex(32'h21, 32'h0000_0021);
        issue(3'd1, 32'h21, 32'h21);
        while (busy_cnt == 0) @(negedge clk);
        rst_req = 1;
        wait_done(1'b0, "R11 bypass reissue");
        cmp_log("R11 bypass reissued in full");
        chk(mem[32'h21] == 32'h21, "R11 bypass word stored", mem[32'h21], 32'h21);
        ex(32'h0, 32'h90); ex(32'h0, 32'h00);
        run(3'd2, 32'h0, 32'h0, 1'b0, "R5 exit after reissue");
        cmp_log("R5 exit after reissue");

        // R7 chip erase, with a request made while busy (R12)
        ex_unlock(); ex(32'h555, 32'h80); ex_unlock(); ex(32'h555, 32'h10);
        issue(3'd3, 32'h0, 32'h0);
        repeat (6) @(negedge clk);
        req = 1'b1; req_op = 3'd0; req_addr = 20'h77; req_data = 32'h77;
        #1;
        chk(ack === 1'b0, "R12 no ack while busy", ack, 0);
        @(negedge clk);
        req = 1'b0;
        wait_done(1'b0, "R7 erase");
        cmp_log("R7 erase writes");
        chk(mem.num() == 0, "R7 array erased", mem.num(), 0);

        // R8 identification
        ex_unlock(); ex(32'h555, 32'h90); ex(32'h0, 32'hF0);
        run(3'd4, 32'h0, 32'h0, 1'b0, "R8 ident");
        cmp_log("R8 ident writes");
        chk(id_code0 == MANUF, "R8 code at offset 0", id_code0, MANUF);
        chk(id_code1 == DEVID, "R8 code at offset 1", id_code1, DEVID);

        // R10 timeout on a device stuck busy
        hang_next = 1;
        ex_unlock(); ex(32'h555, 32'hA0); ex(32'h300, 32'h0000_0300); ex(32'h0, 32'hF0);
        run(3'd0, 32'h300, 32'h300, 1'b1, "R10 timeout");
        cmp_log("R10 timeout writes");
        repeat (3) @(negedge clk);
        chk(err === 1'b1, "R10 err held until next request", err, 1);
        hang = 0; dst = D_RD;

        // R12 unknown op code: error without bus traffic
        run(3'd6, 32'h0, 32'h0, 1'b1, "R12 unknown op");
        cmp_log("R12 no bus activity for unknown op");

        // R10 err cleared by the next accepted request
        ex_unlock(); ex(32'h555, 32'hA0); ex(32'h301, 32'h0000_0301);
        run(3'd0, 32'h301, 32'h301, 1'b0, "R10 clean after error");
        cmp_log("R2 program after error");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule